// File: doc/BRIEF.md
# Banked and Indirect Data-Address Generator

This block produces the 12-bit data-memory address for an 8-bit register-file microcontroller core. In a given cycle the operand is reached in one of three ways. It can be reached directly through a shared fast bank. It can be reached through a bank chosen by a 4-bit bank register. It can also be reached indirectly through one of three 12-bit pointer registers that the block itself holds.

Indirect accesses use one of five modes. The plain mode leaves the pointer alone. Post-increment and post-decrement give the old pointer as the address and then step the pointer. Pre-increment steps the pointer and uses the new value as the address in the same cycle. The offset mode adds the working register, sign-extended, to the pointer. The core can also load a pointer with a 12-bit constant, or add or subtract a small unsigned constant. All pointer arithmetic wraps within the 4 KiB space. The address output is combinational. Pointer changes take effect on the rising clock edge.

Top module: `data_addr_gen`

## Requirements
- R1: With `mode` = 0 (direct) and `bank_sel` = 1, `eff_addr` = {`bsr`, `oper`}.
- R2: With `mode` = 0 and `bank_sel` = 0, `eff_addr` = {4'hF, `oper`} when `oper` >= 8'h60, otherwise {4'h0, `oper`}. Mode codes 6 and 7 behave as code 0.
- R3: With `mode` = 1 (plain indirect), `eff_addr` equals the selected pointer, and the pointer does not change.
- R4: With `mode` = 2 (post-increment) or 3 (post-decrement) and `acc_en` = 1, `eff_addr` is the pointer before the edge. After the edge the pointer is one higher or one lower, modulo 4096 (0xFFF+1 = 0x000, 0x000-1 = 0xFFF).
- R5: With `mode` = 4 (pre-increment), `eff_addr` is the selected pointer plus 1 (mod 4096) in the same cycle. With `acc_en` = 1 the pointer takes that value at the edge.
- R6: With `mode` = 5 (offset), `eff_addr` = pointer + sign-extended `wreg` (mod 4096), and the pointer does not change.
- R7: `ptr_op` = 1 (load) writes `op_imm` into the pointer selected by `ptr_idx`.
- R8: `ptr_op` = 2 (add) or 3 (subtract) adds or subtracts `op_imm[5:0]`, taken as unsigned, to or from the selected pointer, modulo 4096.
- R9: When `ptr_op` is nonzero, the mode-driven step of that cycle is dropped. `eff_addr` is still formed from the pointer value before the edge.
- R10: `ptr_idx` = 3 selects no pointer. No pointer changes, and any indirect mode gives `eff_addr` = 0.
- R11: With `acc_en` = 0, no mode changes a pointer. `eff_addr` is still driven.
- R12: While `rst_n` is low, all three pointers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_en | input | 1 | A memory access happens this cycle (enables mode steps) |
| oper | input | 8 | Operand address field |
| bank_sel | input | 1 | 1 = use bank register, 0 = fast bank |
| bsr | input | 4 | Bank register |
| wreg | input | 8 | Working register, signed offset in mode 5 |
| mode | input | 3 | Addressing mode code (0..5) |
| ptr_idx | input | 2 | Pointer index 0..2, 3 = none |
| ptr_op | input | 2 | 0 none, 1 load, 2 add, 3 subtract |
| op_imm | input | 12 | Load constant; low 6 bits for add/subtract |
| eff_addr | output | 12 | Effective data address |
| ptr_q | output | 36 | Pointers, pointer k in bits [12k+11:12k] |

## Verification
The hardest conditions to reach from the ports are the pointer wrap edges and the clash between an explicit pointer operation and a mode step on the same pointer in one cycle. Random stimulus rarely lands a pointer at exactly 0xFFF or 0x000 while a step mode is active. Directed sequences therefore load those values and then post-increment, post-decrement and pre-increment across the boundary. Random cycles mix pointer operations into about a quarter of the accesses, so the priority rule is exercised in every mode. Directed checks also cover the 0x5F/0x60 fast-bank threshold and negative offsets.

// File: rtl/dag_pkg.sv
package dag_pkg;
    typedef enum logic [2:0] {
        IM_DIRECT  = 3'd0,
        IM_PLAIN   = 3'd1,
        IM_POSTINC = 3'd2,
        IM_POSTDEC = 3'd3,
        IM_PREINC  = 3'd4,
        IM_OFFSET  = 3'd5
    } ind_mode_e;

    typedef enum logic [1:0] {
        PO_NONE = 2'd0,
        PO_LOAD = 2'd1,
        PO_ADD  = 2'd2,
        PO_SUB  = 2'd3
    } ptr_op_e;
endpackage

// File: rtl/dag_direct.sv
module dag_direct #(
    parameter int OW     = 8,
    parameter int BW     = 4,
    parameter int THRESH = 8'h60
) (
    input  logic [OW-1:0]    oper,
    input  logic             bank_sel,
    input  logic [BW-1:0]    bsr,
    output logic [OW+BW-1:0] addr
);
    always_comb begin
        if (bank_sel)
            addr = {bsr, oper};
        else if (int'(oper) >= THRESH)
            addr = {{BW{1'b1}}, oper};
        else
            addr = {{BW{1'b0}}, oper};
    end
endmodule

// File: rtl/dag_ind_calc.sv
module dag_ind_calc
    import dag_pkg::*;
#(
    parameter int AW = 12,
    parameter int DW = 8
) (
    input  logic [AW-1:0] cur_ptr,
    input  logic [DW-1:0] wreg,
    input  logic [2:0]    mode,
    output logic [AW-1:0] addr,
    output logic [AW-1:0] step_val,
    output logic          step_req
);
    localparam int XW = AW - DW;
    logic [AW-1:0] ofs;
    logic [AW-1:0] plus1;

    assign ofs   = {{XW{wreg[DW-1]}}, wreg};
    assign plus1 = cur_ptr + AW'(1);

    always_comb begin
        addr     = cur_ptr;
        step_val = cur_ptr;
        step_req = 1'b0;
        case (ind_mode_e'(mode))
            IM_POSTINC: begin step_val = plus1;              step_req = 1'b1; end
            IM_POSTDEC: begin step_val = cur_ptr - AW'(1);   step_req = 1'b1; end
            IM_PREINC:  begin addr = plus1; step_val = plus1; step_req = 1'b1; end
            IM_OFFSET:  addr = cur_ptr + ofs;
            default:    ;
        endcase
    end
endmodule

// File: rtl/dag_ptr_file.sv
module dag_ptr_file
    import dag_pkg::*;
#(
    parameter int NPTR = 3,
    parameter int AW   = 12,
    parameter int KW   = 6,
    parameter int IW   = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [IW-1:0]      idx,
    input  logic               step_en,
    input  logic [AW-1:0]      step_val,
    input  logic [1:0]         op,
    input  logic [AW-1:0]      op_imm,
    output logic [NPTR*AW-1:0] ptr_q
);
    logic [AW-1:0] k_ext;
    assign k_ext = {{(AW-KW){1'b0}}, op_imm[KW-1:0]};

    for (genvar i = 0; i < NPTR; i++) begin : g_ptr
        logic [AW-1:0] r;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                r <= '0;
            end else if (int'(idx) == i) begin
                unique case (ptr_op_e'(op))
                    PO_LOAD: r <= op_imm;
                    PO_ADD:  r <= r + k_ext;
                    PO_SUB:  r <= r - k_ext;
                    PO_NONE: if (step_en) r <= step_val;
                endcase
            end
        end
        assign ptr_q[i*AW +: AW] = r;
    end
endmodule

// File: rtl/data_addr_gen.sv
module data_addr_gen
    import dag_pkg::*;
#(
    parameter int NPTR = 3,
    parameter int OW   = 8,
    parameter int BW   = 4,
    parameter int DW   = 8,
    parameter int KW   = 6,
    localparam int AW  = OW + BW,
    localparam int IW  = $clog2(NPTR + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               acc_en,
    input  logic [OW-1:0]      oper,
    input  logic               bank_sel,
    input  logic [BW-1:0]      bsr,
    input  logic [DW-1:0]      wreg,
    input  logic [2:0]         mode,
    input  logic [IW-1:0]      ptr_idx,
    input  logic [1:0]         ptr_op,
    input  logic [AW-1:0]      op_imm,
    output logic [AW-1:0]      eff_addr,
    output logic [NPTR*AW-1:0] ptr_q
);
    logic [AW-1:0] dir_addr, ind_addr, step_val, cur_ptr;
    logic          step_req, idx_ok, is_ind;

    assign idx_ok  = int'(ptr_idx) < NPTR;
    assign cur_ptr = idx_ok ? ptr_q[ptr_idx*AW +: AW] : '0;
    assign is_ind  = (mode != 3'd0) && (int'(mode) <= 5);

    dag_direct #(.OW(OW), .BW(BW), .THRESH(8'h60)) u_dir (
        .oper(oper), .bsr(bsr), .bank_sel(bank_sel), .addr(dir_addr)
    );

    dag_ind_calc #(.AW(AW), .DW(DW)) u_ind (
        .cur_ptr(cur_ptr), .wreg(wreg), .mode(mode),
        .addr(ind_addr), .step_val(step_val), .step_req(step_req)
    );

    dag_ptr_file #(.NPTR(NPTR), .AW(AW), .KW(KW), .IW(IW)) u_pf (
        .clk(clk), .rst_n(rst_n), .idx(ptr_idx),
        .step_en(acc_en && step_req && idx_ok), .step_val(step_val),
        .op(ptr_op), .op_imm(op_imm), .ptr_q(ptr_q)
    );

    always_comb begin
        if (!is_ind)     eff_addr = dir_addr;
        else if (idx_ok) eff_addr = ind_addr;
        else             eff_addr = '0;
    end
endmodule

// File: rtl/dag_checker.sv
module dag_checker #(
    parameter int NPTR = 3,
    parameter int AW   = 12,
    parameter int IW   = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               acc_en,
    input logic [7:0]         oper,
    input logic               bank_sel,
    input logic [3:0]         bsr,
    input logic [2:0]         mode,
    input logic [IW-1:0]      ptr_idx,
    input logic [1:0]         ptr_op,
    input logic [AW-1:0]      op_imm,
    input logic [AW-1:0]      eff_addr,
    input logic [NPTR*AW-1:0] ptr_q
);
    function automatic logic [AW-1:0] pick(input logic [NPTR*AW-1:0] v, input logic [IW-1:0] i);
        return v[i*AW +: AW];
    endfunction

    a_r1_banked: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd0 && bank_sel) |-> eff_addr == {bsr, oper});

    a_r3_plain_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd1 && ptr_op == 2'd0 && int'(ptr_idx) < NPTR) |=> $stable(ptr_q));

    a_r4_postinc: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && mode == 3'd2 && ptr_op == 2'd0 && int'(ptr_idx) < NPTR)
        |=> pick(ptr_q, $past(ptr_idx)) == $past(eff_addr) + AW'(1));

    a_r5_preinc: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && mode == 3'd4 && ptr_op == 2'd0 && int'(ptr_idx) < NPTR)
        |=> pick(ptr_q, $past(ptr_idx)) == $past(eff_addr));

    a_r7_load: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_op == 2'd1 && int'(ptr_idx) < NPTR)
        |=> pick(ptr_q, $past(ptr_idx)) == $past(op_imm));

    a_r10_no_target: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(ptr_idx) >= NPTR) |=> $stable(ptr_q));

    a_r11_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_en && ptr_op == 2'd0) |=> $stable(ptr_q));
endmodule

bind data_addr_gen dag_checker #(.NPTR(NPTR), .AW(AW), .IW(IW)) u_chk (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .oper(oper), .bank_sel(bank_sel),
    .bsr(bsr), .mode(mode), .ptr_idx(ptr_idx), .ptr_op(ptr_op), .op_imm(op_imm),
    .eff_addr(eff_addr), .ptr_q(ptr_q)
);

// File: tb/tb_data_addr_gen.sv
module tb_data_addr_gen;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0, rst_n = 1'b0, acc_en = 1'b0, bank_sel = 1'b0;
    logic [7:0]  oper = '0, wreg = '0;
    logic [3:0]  bsr = '0;
    logic [2:0]  mode = '0;
    logic [1:0]  ptr_idx = '0, ptr_op = '0;
    logic [11:0] op_imm = '0, eff_addr;
    logic [35:0] ptr_q;

    logic [11:0] m [3];
    int total = 0, bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    data_addr_gen dut (
        .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .oper(oper), .bank_sel(bank_sel),
        .bsr(bsr), .wreg(wreg), .mode(mode), .ptr_idx(ptr_idx), .ptr_op(ptr_op),
        .op_imm(op_imm), .eff_addr(eff_addr), .ptr_q(ptr_q)
    );

    task automatic check(input string req, input logic [35:0] act, input logic [35:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [11:0] exp_addr();
        logic [11:0] p;
        p = (ptr_idx < 3) ? m[ptr_idx] : 12'h0;
        case (mode)
            3'd1, 3'd2, 3'd3: return (ptr_idx < 3) ? p : 12'h0;
            3'd4: return (ptr_idx < 3) ? p + 12'd1 : 12'h0;
            3'd5: return (ptr_idx < 3) ? p + {{4{wreg[7]}}, wreg} : 12'h0;
            default: begin
                if (bank_sel) return {bsr, oper};
                return (oper >= 8'h60) ? {4'hF, oper} : {4'h0, oper};
            end
        endcase
    endfunction

    function automatic string req_of();
        if (ptr_idx == 2'd3) return "R10";
        if (ptr_op == 2'd1) return "R7";
        if (ptr_op != 2'd0) return (acc_en && mode inside {3'd2,3'd3,3'd4}) ? "R9" : "R8";
        if (!acc_en) return "R11";
        case (mode)
            3'd1: return "R3";
            3'd2, 3'd3: return "R4";
            3'd4: return "R5";
            3'd5: return "R6";
            default: return bank_sel ? "R1" : "R2";
        endcase
    endfunction

    task automatic model_step();
        if (ptr_idx < 3) begin
            case (ptr_op)
                2'd1: m[ptr_idx] = op_imm;
                2'd2: m[ptr_idx] = m[ptr_idx] + {6'd0, op_imm[5:0]};
                2'd3: m[ptr_idx] = m[ptr_idx] - {6'd0, op_imm[5:0]};
                default: if (acc_en) case (mode)
                    3'd2, 3'd4: m[ptr_idx] = m[ptr_idx] + 12'd1;
                    3'd3:       m[ptr_idx] = m[ptr_idx] - 12'd1;
                    default: ;
                endcase
            endcase
        end
    endtask

    // inputs already applied after a negedge; check address, clock, check pointers
    task automatic cycle();
        string r;
        #1;
        r = req_of();
        check({r, " addr"}, {24'd0, eff_addr}, {24'd0, exp_addr()});
        model_step();
        @(posedge clk); #1;
        check({r, " ptr"}, ptr_q, {m[2], m[1], m[0]});
        @(negedge clk);
    endtask

    task automatic drive(input logic a, input logic [2:0] md, input logic [1:0] ix,
                         input logic [1:0] op, input logic [11:0] imm);
        acc_en = a; mode = md; ptr_idx = ix; ptr_op = op; op_imm = imm;
        cycle();
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED));
        for (int i = 0; i < 3; i++) m[i] = '0;
        #(CLK_PERIOD * 2 + 3);
        check("R12 reset", ptr_q, 36'd0);
        @(negedge clk); rst_n = 1'b1;

        // R2 threshold corner
        bank_sel = 0; oper = 8'h5F; drive(1, 3'd0, 2'd3, 2'd0, 12'h0);
        oper = 8'h60; drive(1, 3'd7, 2'd3, 2'd0, 12'h0);
        // R1
        bank_sel = 1; bsr = 4'h9; oper = 8'h12; drive(1, 3'd0, 2'd0, 2'd0, 12'h0);
        // R7 / R4 wrap
        drive(0, 3'd0, 2'd0, 2'd1, 12'hFFF);
        drive(1, 3'd2, 2'd0, 2'd0, 12'h0);   // R4 0xFFF -> 0x000
        drive(1, 3'd3, 2'd0, 2'd0, 12'h0);   // R4 0x000 -> 0xFFF
        drive(1, 3'd4, 2'd0, 2'd0, 12'h0);   // R5 pre-inc wrap
        // R6 negative offset
        drive(0, 3'd1, 2'd1, 2'd1, 12'h010);
        wreg = 8'hF0; drive(1, 3'd5, 2'd1, 2'd0, 12'h0);
        // R8 add/sub with extra high imm bits ignored
        drive(0, 3'd0, 2'd2, 2'd2, 12'hFC5);
        drive(0, 3'd0, 2'd2, 2'd3, 12'h03F);
        // R9 priority: op against post-inc
        drive(1, 3'd2, 2'd1, 2'd2, 12'h004);
        // R10 / R11
        drive(1, 3'd2, 2'd3, 2'd1, 12'h123);
        drive(0, 3'd4, 2'd1, 2'd0, 12'h0);

        for (int n = 0; n < 3000; n++) begin
            oper = 8'($urandom); bsr = 4'($urandom); wreg = 8'($urandom);
            bank_sel = 1'($urandom);
            drive(($urandom % 4) != 0, 3'($urandom), 2'($urandom),
                  (($urandom % 4) == 0) ? 2'($urandom) : 2'd0, 12'($urandom));
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule